// File: doc/BRIEF.md
# Key-Tone Beeper with Watchdog Service

This block sounds a short square-wave tone on a buzzer line each time a key code is presented with a load strobe. The key code, taken as an offset from the character `'0'` (0x30), selects one of 41 tones. Each tone is defined by two values. The first is a half-period reload, the number of clocks between buzzer edges. The second is a half-cycle count, the number of buzzer edges to produce. The two are paired so that every tone lasts close to 0.1 s at a 2 MHz clock, whatever its pitch.

A free-running tick timer paces the buzzer edges. The same tick services an external watchdog. The watchdog line rests high and dips low for exactly one clock on every tick, which gives a high-low-high pulse. With no tone loaded, the timer keeps running at a default period of 2000 clocks (1 ms at 2 MHz), so the watchdog is serviced even when the beeper is silent.

Two enumerated machines control the block. The tone machine has the states BEEP_SILENT and BEEP_TONE. It moves from BEEP_SILENT to BEEP_TONE on a valid load, and it stays in BEEP_TONE when a new valid load arrives during a tone. It returns from BEEP_TONE to BEEP_SILENT on the tick that uses up the last half-cycle. The watchdog machine has the states WD_RESTORED and WD_DIP. It moves from WD_RESTORED to WD_DIP on a tick, and from WD_DIP back to WD_RESTORED on the next clock. Two parameters divide the tables down for small test configurations: `RELOAD_SHIFT` shifts the reload values right and `COUNT_SHIFT` shifts the half-cycle counts right.

Top module: `key_tone_beeper`

## Requirements
- R1: A load is accepted only when `key_code` lies in 0x30..0x58. The tone index is `key_code - 0x30`, which gives 0..40.
- R2: While a tone sounds, the buzzer toggles once every P clocks. P is the index's entry in the half-period table (0x0341 for index 0 down to 0x00E3 for index 40), shifted right by `RELOAD_SHIFT`.
- R3: A tone produces exactly N buzzer toggles and then stops. N = (0x00F0 + 0x10 × index) >> `COUNT_SHIFT`.
- R4: A valid load restarts the timer at once. When the load is captured at clock edge E, the first toggle occurs at edge E+P.
- R5: After reset the buzzer is low, the watchdog line is high, and no toggles occur. Ticks then arrive every 0x07D0 >> `RELOAD_SHIFT` clocks, counted from the first edge after reset release.
- R6: On every tick the watchdog line is low for exactly one clock. It is high at all other times.
- R7: A load strobe with a code outside 0x30..0x58 has no effect. The tick phase, the tick period and the buzzer level are all unchanged.
- R8: When a tone ends, the buzzer holds its level and the timer keeps ticking at the last tone's period P.
- R9: A valid load during a tone replaces the reload and the count together. The load itself leaves the buzzer level unchanged, so after the new N toggles (N is always even) the buzzer returns to the level it had at the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; table units are clock cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_code | input | KEY_W | Key character code |
| key_load | input | 1 | Strobe: accept `key_code` at this edge |
| buzzer | output | 1 | Square-wave buzzer drive, idles low |
| wdog | output | 1 | Watchdog service line, rests high, one-clock low dip per tick |

## Verification
The bench loads each of the 41 valid codes in turn from silence. For each one it checks the first toggle time, the toggle spacing, the toggle count, the end level and the watchdog dips against P and N computed from the index. The sweep covers both extremes of pitch and duration. The bench then loads a new key in the middle of a tone that is left high. This separates a load that preserves the buzzer level from one that resets it, and an atomic replacement from one that keeps the old count. Finally, three out-of-range codes are strobed exactly one clock after a tick. A design that wrongly restarts the timer would shift the next dip by one clock, so this test distinguishes a load that is truly ignored from one that silently restarts the timer.

// File: rtl/kt_pkg.sv
package kt_pkg;

    localparam int TONE_COUNT = 41;
    localparam int TONE_IDX_W = 6;
    localparam int HC_BASE    = 16'h00F0;
    localparam int HC_STEP    = 16'h0010;

    typedef enum logic {
        BEEP_SILENT,
        BEEP_TONE
    } beep_state_e;

    typedef enum logic {
        WD_RESTORED,
        WD_DIP
    } wd_state_e;

    // Half-period, in clocks, between buzzer edges for each tone index.
    function automatic logic [15:0] tone_half_period(input logic [TONE_IDX_W-1:0] idx);
        logic [15:0] hp;
        unique case (idx)
            6'd0:  hp = 16'h0341;
            6'd1:  hp = 16'h030D;
            6'd2:  hp = 16'h02DF;
            6'd3:  hp = 16'h02B6;
            6'd4:  hp = 16'h0291;
            6'd5:  hp = 16'h0271;
            6'd6:  hp = 16'h0253;
            6'd7:  hp = 16'h0238;
            6'd8:  hp = 16'h021F;
            6'd9:  hp = 16'h0208;
            6'd10: hp = 16'h01F4;
            6'd11: hp = 16'h01E0;
            6'd12: hp = 16'h01CE;
            6'd13: hp = 16'h01BE;
            6'd14: hp = 16'h01AF;
            6'd15: hp = 16'h01A0;
            6'd16: hp = 16'h0193;
            6'd17: hp = 16'h0186;
            6'd18: hp = 16'h017A;
            6'd19: hp = 16'h016F;
            6'd20: hp = 16'h0165;
            6'd21: hp = 16'h015B;
            6'd22: hp = 16'h0151;
            6'd23: hp = 16'h0148;
            6'd24: hp = 16'h0140;
            6'd25: hp = 16'h0138;
            6'd26: hp = 16'h0130;
            6'd27: hp = 16'h0129;
            6'd28: hp = 16'h0122;
            6'd29: hp = 16'h011C;
            6'd30: hp = 16'h0115;
            6'd31: hp = 16'h010F;
            6'd32: hp = 16'h0109;
            6'd33: hp = 16'h0104;
            6'd34: hp = 16'h00FF;
            6'd35: hp = 16'h00FA;
            6'd36: hp = 16'h00F5;
            6'd37: hp = 16'h00F0;
            6'd38: hp = 16'h00EB;
            6'd39: hp = 16'h00E7;
            6'd40: hp = 16'h00E3;
            default: hp = 16'h0000;
        endcase
        return hp;
    endfunction

endpackage

// File: rtl/kt_tone_rom.sv
module kt_tone_rom
    import kt_pkg::*;
#(
    parameter int KEY_W        = 8,
    parameter int BASE_CODE    = 48,
    parameter int TMR_W        = 16,
    parameter int CNT_W        = 16,
    parameter int RELOAD_SHIFT = 0,
    parameter int COUNT_SHIFT  = 0
) (
    input  logic [KEY_W-1:0] key_code,
    output logic             hit,
    output logic [TMR_W-1:0] half_period,
    output logic [CNT_W-1:0] half_cycles
);
    localparam logic [KEY_W-1:0] BASE_K  = KEY_W'(BASE_CODE);
    localparam logic [KEY_W-1:0] LIMIT_K = KEY_W'(TONE_COUNT);

    logic [KEY_W-1:0]      offset;
    logic [TONE_IDX_W-1:0] idx;
    logic [15:0]           hp_raw;
    logic [CNT_W-1:0]      hc_raw;

    always_comb begin
        offset = key_code - BASE_K;
        hit    = (key_code >= BASE_K) && (offset < LIMIT_K);
        idx    = offset[TONE_IDX_W-1:0];
        hp_raw = tone_half_period(idx);
        hc_raw = CNT_W'(HC_BASE) + CNT_W'(idx) * CNT_W'(HC_STEP);
        half_period = TMR_W'(hp_raw >> RELOAD_SHIFT);
        half_cycles = hc_raw >> COUNT_SHIFT;
    end

endmodule

// File: rtl/kt_tick_timer.sv
module kt_tick_timer #(
    parameter int TMR_W      = 16,
    parameter int DEF_PERIOD = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             tick
);
    localparam logic [TMR_W-1:0] DEF_P = TMR_W'(DEF_PERIOD);
    localparam logic [TMR_W-1:0] ONE   = TMR_W'(1);

    logic [TMR_W-1:0] period_q;
    logic [TMR_W-1:0] cnt_q;

    // A load wins over an underflow in the same cycle.
    assign tick = (cnt_q == ONE) && !load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= DEF_P;
            cnt_q    <= DEF_P;
        end else if (load) begin
            period_q <= load_val;
            cnt_q    <= load_val;
        end else if (cnt_q == ONE) begin
            cnt_q    <= period_q;
        end else begin
            cnt_q    <= cnt_q - ONE;
        end
    end

    // R4: a fresh load always defers the next tick by at least two clocks
    a_r4_load_defers_tick: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !tick);

    // R8: period register only changes through a load
    a_r8_period_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(period_q));

endmodule

// File: rtl/kt_wdog_kick.sv
module kt_wdog_kick
    import kt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic wdog
);
    wd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_RESTORED: if (tick) state_d = WD_DIP;
            WD_DIP:      state_d = WD_RESTORED;
            default:     state_d = WD_RESTORED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_RESTORED;
        else        state_q <= state_d;
    end

    always_comb begin
        wdog = (state_q != WD_DIP);
    end

    a_r6_dip_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !wdog);

    a_r6_dip_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !wdog |=> wdog);

    a_r6_no_dip_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> wdog);

endmodule

// File: rtl/key_tone_beeper.sv
module key_tone_beeper
    import kt_pkg::*;
#(
    parameter int KEY_W        = 8,
    parameter int BASE_CODE    = 48,
    parameter int TMR_W        = 16,
    parameter int CNT_W        = 16,
    parameter int DEF_RELOAD   = 2000,
    parameter int RELOAD_SHIFT = 0,
    parameter int COUNT_SHIFT  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_code,
    input  logic             key_load,
    output logic             buzzer,
    output logic             wdog
);
    localparam int               DEF_PERIOD = DEF_RELOAD >> RELOAD_SHIFT;
    localparam logic [CNT_W-1:0] C_ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_ZERO     = '0;

    logic             hit;
    logic             accept;
    logic             tick;
    logic [TMR_W-1:0] half_period;
    logic [CNT_W-1:0] half_cycles;

    beep_state_e      state_q, state_d;
    logic [CNT_W-1:0] left_q,  left_d;
    logic             buzz_q;

    kt_tone_rom #(
        .KEY_W       (KEY_W),
        .BASE_CODE   (BASE_CODE),
        .TMR_W       (TMR_W),
        .CNT_W       (CNT_W),
        .RELOAD_SHIFT(RELOAD_SHIFT),
        .COUNT_SHIFT (COUNT_SHIFT)
    ) u_rom (
        .key_code   (key_code),
        .hit        (hit),
        .half_period(half_period),
        .half_cycles(half_cycles)
    );

    assign accept = key_load && hit;

    kt_tick_timer #(
        .TMR_W     (TMR_W),
        .DEF_PERIOD(DEF_PERIOD)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(half_period),
        .tick    (tick)
    );

    kt_wdog_kick u_wdog (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .wdog (wdog)
    );

    // Next-state and remaining half-cycle logic
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            BEEP_SILENT: begin
                if (accept) begin
                    state_d = BEEP_TONE;
                    left_d  = half_cycles;
                end
            end
            BEEP_TONE: begin
                if (accept) begin
                    left_d  = half_cycles;
                end else if (tick) begin
                    left_d  = left_q - C_ONE;
                    if (left_q == C_ONE) state_d = BEEP_SILENT;
                end
            end
            default: begin
                state_d = BEEP_SILENT;
                left_d  = C_ZERO;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BEEP_SILENT;
            left_q  <= C_ZERO;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // Output register: toggle on each tick while a tone sounds
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         buzz_q <= 1'b0;
        else if (state_q == BEEP_TONE && tick) buzz_q <= ~buzz_q;
    end

    assign buzzer = buzz_q;

    // R2: the buzzer moves only on a tick
    a_r2_edge_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(buzzer));

    // R3: a silent beeper with no accepted load keeps its level
    a_r3_silent_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BEEP_SILENT && !accept) |=> $stable(buzzer));

    // R3: the last half-cycle returns the machine to silence
    a_r3_ends_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BEEP_TONE && tick && left_q == C_ONE) |=> state_q == BEEP_SILENT);

    // R7: a rejected code leaves the remaining count alone unless a tick spends it
    a_r7_reject_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (key_load && !hit && !tick) |=> $stable(left_q));

    // R9: an accepted load never flips the buzzer at its own edge
    a_r9_load_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> $stable(buzzer));

endmodule

// File: tb/key_tone_beeper_test.sv
module key_tone_beeper_test;

    localparam int RS  = 4;
    localparam int CS  = 3;
    localparam int DEF = 2000 >> RS;

    localparam int HP [41] = '{
        'h341, 'h30D, 'h2DF, 'h2B6, 'h291, 'h271, 'h253, 'h238, 'h21F, 'h208,
        'h1F4, 'h1E0, 'h1CE, 'h1BE, 'h1AF, 'h1A0, 'h193, 'h186, 'h17A, 'h16F,
        'h165, 'h15B, 'h151, 'h148, 'h140, 'h138, 'h130, 'h129, 'h122, 'h11C,
        'h115, 'h10F, 'h109, 'h104, 'h0FF, 'h0FA, 'h0F5, 'h0F0, 'h0EB, 'h0E7,
        'h0E3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] key_code = 8'h00;
    logic       key_load = 1'b0;
    logic       buzzer;
    logic       wdog;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    key_tone_beeper #(
        .RELOAD_SHIFT(RS),
        .COUNT_SHIFT (CS)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_code(key_code),
        .key_load(key_load),
        .buzzer  (buzzer),
        .wdog    (wdog)
    );

    function automatic int exp_p(input int i);
        return HP[i] >> RS;
    endfunction

    function automatic int exp_n(input int i);
        return (240 + 16 * i) >> CS;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_load(input logic [7:0] code);
        @(negedge clk);
        key_code = code;
        key_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        key_load = 1'b0;
    endtask

    // Observe win clocks after a load/reset edge; checks R2, R3, R4, R6, R8
    task automatic observe(input int p, input int n, input int win,
                           input logic lvl_end, input string tag);
        int   tog = 0;
        int   last = 0;
        int   first_k = -1;
        int   sp_err = 0;
        int   wd_n = 0;
        int   wd_err = 0;
        logic prev;
        prev = buzzer;
        for (int k = 1; k <= win; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (buzzer !== prev) begin
                tog++;
                if (tog == 1) first_k = k;
                else if (k - last != p) sp_err++;
                last = k;
                prev = buzzer;
            end
            if (wdog === 1'b0) begin
                wd_n++;
                if (k % p != 0) wd_err++;
            end
        end
        check(tog == n, "R3", {tag, " toggle count"}, tog, n);
        if (n > 0) check(first_k == p, "R4", {tag, " first toggle clock"}, first_k, p);
        check(sp_err == 0, "R2", {tag, " toggle spacing errors"}, sp_err, 0);
        check(wd_n == win / p && wd_err == 0, "R6", {tag, " watchdog dips"}, wd_n, win / p);
        check(buzzer === lvl_end, "R8", {tag, " final level"}, int'(buzzer), int'(lvl_end));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual 1 expected 0");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        // R5: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(buzzer === 1'b0, "R5", "reset buzzer", int'(buzzer), 0);
        check(wdog === 1'b1, "R5", "reset watchdog", int'(wdog), 1);
        rst_n = 1'b1;
        observe(DEF, 0, 3 * DEF, 1'b0, "R5 idle");

        // R1, R2, R3, R4, R6, R8: sweep all valid codes from silence
        for (int i = 0; i < 41; i++) begin
            apply_load(8'(8'h30 + i));
            observe(exp_p(i), exp_n(i), (exp_n(i) + 3) * exp_p(i), 1'b0, $sformatf("R1 key %0d", i));
        end

        // R7: out-of-range codes strobed one clock after a dip
        begin
            logic [7:0] bad [3] = '{8'h2F, 8'h59, 8'hFF};
            int p = exp_p(40);
            for (int b = 0; b < 3; b++) begin
                int   first_k = -1;
                int   moved = 0;
                logic lvl;
                lvl = buzzer;
                key_code = bad[b];
                key_load = 1'b1;
                for (int k = 1; k <= 2 * p; k++) begin
                    @(posedge clk);
                    @(negedge clk);
                    key_load = 1'b0;
                    if (wdog === 1'b0 && first_k < 0) first_k = k;
                    if (buzzer !== lvl) moved++;
                end
                check(first_k == p, "R7", $sformatf("code %0h tick phase", bad[b]), first_k, p);
                check(moved == 0, "R7", $sformatf("code %0h buzzer moved", bad[b]), moved, 0);
            end
        end

        // R9: reload during a tone left high
        begin
            int p0 = exp_p(0);
            apply_load(8'h30);
            repeat (5 * p0) begin
                @(posedge clk);
                @(negedge clk);
            end
            check(buzzer === 1'b1, "R9", "level before retrigger", int'(buzzer), 1);
            apply_load(8'h30 + 8'd20);
            check(buzzer === 1'b1, "R9", "level right after retrigger", int'(buzzer), 1);
            observe(exp_p(20), exp_n(20), (exp_n(20) + 3) * exp_p(20), 1'b1, "R9 retrigger");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule